// File: doc/BRIEF.md
# Scalar ALU with Condition Flag

This block executes one scalar two-operand instruction. It takes a 32-bit instruction word, the two operand values that have already been read from the register file, and the present value of the one-bit scalar condition flag. It decodes the word and produces a 32-bit result, the destination register index, a write strobe for the result, the next value of the condition flag, and a flag that marks an illegal encoding.

The operations are unsigned and signed add and subtract, add with carry-in, subtract with borrow-in, signed and unsigned min and max, conditional select, multiply (low half), eight bitwise logic functions, three shifts and signed absolute difference. Each operation has its own rule for the condition flag. The flag can hold the carry or borrow, the signed overflow, the result of the operand comparison, or whether the result is non-zero, or it can keep its old value. The carry-in and borrow-in come from the incoming flag. The datapath is combinational. A registered stage captures the outcome one clock after a valid strobe.

Top module: `salu_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, wr_en, illegal, scc_out, result and dst_idx are all zero.
- R2: An instruction presented with in_valid is reflected on the outputs exactly one clock later, with out_valid high and dst_idx equal to instruction bits [22:16]. In a cycle without in_valid, out_valid, wr_en and illegal fall low and result and scc_out keep their values.
- R3: Instruction bits [31:30] must be 2'b10. Any other value sets illegal, clears wr_en, forces result to zero and passes scc_in through unchanged to scc_out.
- R4: The opcode is instruction bits [29:23]. Opcodes 11 and 25 to 127 are unassigned and are treated like a bad encoding (illegal set, no write, result zero, flag kept). Every assigned opcode raises wr_en.
- R5: Opcode 0 (unsigned add) returns the low 32 bits of src0+src1 and sets the flag to the carry out of bit 31. Opcode 4 also adds scc_in and sets the flag to the carry out.
- R6: Opcode 1 (unsigned subtract) returns src0-src1 and sets the flag when a borrow occurs. Opcode 5 also subtracts scc_in and sets the flag to the borrow out.
- R7: Opcodes 2 (signed add) and 3 (signed subtract) return the wrapped 32-bit result. The flag is set when the exact result lies outside -2^31 .. 2^31-1.
- R8: Opcodes 6/7 (min signed/unsigned) and 8/9 (max signed/unsigned) return the chosen operand. The flag is set only when src0 is strictly smaller (min) or strictly larger (max). Equal operands give a flag of 0.
- R9: Opcode 10 returns src0 when scc_in is 1 and src1 when it is 0. Opcode 23 returns the low 32 bits of src0*src1. Both pass scc_in through unchanged.
- R10: Opcodes 12 to 19 compute AND, OR, XOR, src0&~src1, src0|~src1, NAND, NOR and XNOR. The flag is 1 exactly when the result is non-zero.
- R11: Opcodes 20, 21 and 22 shift src0 left, logically right and arithmetically right by src1[4:0]. The flag is 1 exactly when the result is non-zero.
- R12: Opcode 24 returns the low 32 bits of |src0-src1|, computed on the exact signed difference. The flag is 1 exactly when that result is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src0 | input | 32 | First operand value |
| src1 | input | 32 | Second operand value |
| scc_in | input | 1 | Current condition flag |
| out_valid | output | 1 | Registered outcome is valid |
| dst_idx | output | 7 | Destination register index |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Result should be written back |
| scc_out | output | 1 | Next condition flag |
| illegal | output | 1 | Encoding or opcode was not accepted |

## Verification
The arithmetic opcodes are driven with operands at the carry, borrow and overflow boundaries: all ones plus one, zero minus one, the most positive signed value plus one and the most negative minus one. Each of these shows whether the flag comes from the unsigned carry, the borrow or the signed overflow rule, and whether the incoming flag is added or subtracted. Equal operands for min and max tell the strict comparison apart from a non-strict one. Logic operations whose result is zero, shift amounts above 31 and negative values for the arithmetic shift separate the non-zero rule and the 5-bit mask from the alternatives. Seeded random words over all opcodes, mixed with bad encodings, cover the rest, and each result is compared against an independent model.

// File: rtl/salu_pkg.sv
package salu_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 7;
    localparam int DST_W    = 7;
    localparam int ENC_HI   = 31;
    localparam int ENC_LO   = 30;
    localparam int OPC_HI   = 29;
    localparam int OPC_LO   = 23;
    localparam int DST_HI   = 22;
    localparam int DST_LO   = 16;
    localparam logic [1:0] ENC_OK = 2'b10;

    typedef enum logic [OPC_W-1:0] {
        OP_ADDU = 7'd0,
        OP_SUBU = 7'd1,
        OP_ADDS = 7'd2,
        OP_SUBS = 7'd3,
        OP_ADDC = 7'd4,
        OP_SUBB = 7'd5,
        OP_MINS = 7'd6,
        OP_MINU = 7'd7,
        OP_MAXS = 7'd8,
        OP_MAXU = 7'd9,
        OP_CSEL = 7'd10,
        OP_AND  = 7'd12,
        OP_OR   = 7'd13,
        OP_XOR  = 7'd14,
        OP_ANDN = 7'd15,
        OP_ORN  = 7'd16,
        OP_NAND = 7'd17,
        OP_NOR  = 7'd18,
        OP_XNOR = 7'd19,
        OP_SHL  = 7'd20,
        OP_SHR  = 7'd21,
        OP_ASHR = 7'd22,
        OP_MUL  = 7'd23,
        OP_ABSD = 7'd24
    } opc_e;

endpackage

// File: rtl/salu_decode.sv
module salu_decode
    import salu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output opc_e               op,
    output logic [DST_W-1:0]   dst,
    output logic               legal,
    output logic               use_arith
);

    logic [OPC_W-1:0] opc_raw;
    logic             enc_ok;
    logic             opc_known;

    always_comb begin
        opc_raw   = instr[OPC_HI:OPC_LO];
        op        = opc_e'(opc_raw);
        dst       = instr[DST_HI:DST_LO];
        enc_ok    = (instr[ENC_HI:ENC_LO] == ENC_OK);
        opc_known = 1'b1;
        use_arith = 1'b0;
        case (op)
            OP_ADDU, OP_SUBU, OP_ADDS, OP_SUBS, OP_ADDC, OP_SUBB,
            OP_MINS, OP_MINU, OP_MAXS, OP_MAXU, OP_ABSD:
                use_arith = 1'b1;
            OP_CSEL, OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_NAND,
            OP_NOR, OP_XNOR, OP_SHL, OP_SHR, OP_ASHR, OP_MUL:
                use_arith = 1'b0;
            default:
                opc_known = 1'b0;
        endcase
        legal = enc_ok && opc_known;
    end

endmodule

// File: rtl/salu_arith.sv
module salu_arith
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  opc_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         flag_in,
    output logic [W-1:0] res,
    output logic         flag_out
);

    localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

    logic [W:0] sum_x;
    logic [W:0] dif_x;
    logic [W:0] sdif_x;
    logic [W:0] mag_x;
    logic       cin_add;
    logic       cin_sub;
    logic       lt_s;
    logic       lt_u;
    logic       eq;

    always_comb begin
        cin_add = (op == OP_ADDC) && flag_in;
        cin_sub = (op == OP_SUBB) && flag_in;
        sum_x   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin_add};
        dif_x   = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin_sub};
        sdif_x  = {a[W-1], a} - {b[W-1], b};
        mag_x   = sdif_x[W] ? ((~sdif_x) + ONE_X) : sdif_x;
        lt_s    = $signed(a) < $signed(b);
        lt_u    = a < b;
        eq      = (a == b);

        res      = '0;
        flag_out = flag_in;
        case (op)
            OP_ADDU, OP_ADDC: begin
                res      = sum_x[W-1:0];
                flag_out = sum_x[W];
            end
            OP_SUBU, OP_SUBB: begin
                res      = dif_x[W-1:0];
                flag_out = dif_x[W];
            end
            OP_ADDS: begin
                res      = sum_x[W-1:0];
                flag_out = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
            end
            OP_SUBS: begin
                res      = dif_x[W-1:0];
                flag_out = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
            end
            OP_MINS: begin
                res      = lt_s ? a : b;
                flag_out = lt_s;
            end
            OP_MINU: begin
                res      = lt_u ? a : b;
                flag_out = lt_u;
            end
            OP_MAXS: begin
                res      = (!lt_s && !eq) ? a : b;
                flag_out = !lt_s && !eq;
            end
            OP_MAXU: begin
                res      = (!lt_u && !eq) ? a : b;
                flag_out = !lt_u && !eq;
            end
            OP_ABSD: begin
                res      = mag_x[W-1:0];
                flag_out = |mag_x[W-1:0];
            end
            default: begin
                res      = '0;
                flag_out = flag_in;
            end
        endcase
    end

endmodule

// File: rtl/salu_logic.sv
module salu_logic
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  opc_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         flag_in,
    output logic [W-1:0] res,
    output logic         flag_out
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;
    logic [W-1:0]   prod;
    logic           keep_flag;

    always_comb begin
        sh        = b[SHW-1:0];
        prod      = a * b;
        keep_flag = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_ANDN: res = a & ~b;
            OP_ORN:  res = a | ~b;
            OP_NAND: res = ~(a & b);
            OP_NOR:  res = ~(a | b);
            OP_XNOR: res = ~(a ^ b);
            OP_SHL:  res = a << sh;
            OP_SHR:  res = a >> sh;
            OP_ASHR: res = W'($signed(a) >>> sh);
            OP_MUL: begin
                res       = prod;
                keep_flag = 1'b1;
            end
            OP_CSEL: begin
                res       = flag_in ? a : b;
                keep_flag = 1'b1;
            end
            default: begin
                res       = '0;
                keep_flag = 1'b1;
            end
        endcase
        flag_out = keep_flag ? flag_in : (|res);
    end

endmodule

// File: rtl/salu_core.sv
module salu_core
    import salu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  src0,
    input  logic [DATA_W-1:0]  src1,
    input  logic               scc_in,
    output logic               out_valid,
    output logic [DST_W-1:0]   dst_idx,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic               scc_out,
    output logic               illegal
);

    typedef struct packed {
        logic              valid;
        logic [DST_W-1:0]  dst;
        logic [DATA_W-1:0] res;
        logic              wr;
        logic              scc;
        logic              ill;
    } stage_t;

    opc_e              dec_op;
    logic [DST_W-1:0]  dec_dst;
    logic              dec_legal;
    logic              dec_arith;
    logic [DATA_W-1:0] ar_res;
    logic              ar_flag;
    logic [DATA_W-1:0] lg_res;
    logic              lg_flag;

    stage_t st_d;
    stage_t st_q;

    salu_decode u_decode (
        .instr     (instr),
        .op        (dec_op),
        .dst       (dec_dst),
        .legal     (dec_legal),
        .use_arith (dec_arith)
    );

    salu_arith #(.W(DATA_W)) u_arith (
        .op       (dec_op),
        .a        (src0),
        .b        (src1),
        .flag_in  (scc_in),
        .res      (ar_res),
        .flag_out (ar_flag)
    );

    salu_logic #(.W(DATA_W)) u_logic (
        .op       (dec_op),
        .a        (src0),
        .b        (src1),
        .flag_in  (scc_in),
        .res      (lg_res),
        .flag_out (lg_flag)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.wr    = 1'b0;
        st_d.ill   = 1'b0;
        if (in_valid) begin
            st_d.valid = 1'b1;
            st_d.dst   = dec_dst;
            st_d.wr    = dec_legal;
            st_d.ill   = !dec_legal;
            if (!dec_legal) begin
                st_d.res = '0;
                st_d.scc = scc_in;
            end else if (dec_arith) begin
                st_d.res = ar_res;
                st_d.scc = ar_flag;
            end else begin
                st_d.res = lg_res;
                st_d.scc = lg_flag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign dst_idx   = st_q.dst;
    assign result    = st_q.res;
    assign wr_en     = st_q.wr;
    assign scc_out   = st_q.scc;
    assign illegal   = st_q.ill;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wr_en && $stable(result) && $stable(scc_out)); // R2

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en && out_valid); // R4

    AST_BAD_ENC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[ENC_HI:ENC_LO] != ENC_OK) |=> illegal && (scc_out == $past(scc_in))); // R3

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[ENC_HI:OPC_LO] == {ENC_OK, 7'd0})
        |=> {scc_out, result} == ({1'b0, $past(src0)} + {1'b0, $past(src1)})); // R5

    AST_CSEL_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[ENC_HI:OPC_LO] == {ENC_OK, 7'd10})
        |=> (scc_out == $past(scc_in)) && (result == ($past(scc_in) ? $past(src0) : $past(src1)))); // R9

    AST_LOGIC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[ENC_HI:ENC_LO] == ENC_OK &&
         instr[OPC_HI:OPC_LO] >= 7'd12 && instr[OPC_HI:OPC_LO] <= 7'd19)
        |=> scc_out == (result != '0)); // R10

endmodule

// File: tb/salu_core_tb.sv
`timescale 1ns/1ps
module salu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src0 = '0;
    logic [31:0] src1 = '0;
    logic        scc_in = 1'b0;
    logic        out_valid;
    logic [6:0]  dst_idx;
    logic [31:0] result;
    logic        wr_en;
    logic        scc_out;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    salu_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src0(src0), .src1(src1), .scc_in(scc_in), .out_valid(out_valid),
        .dst_idx(dst_idx), .result(result), .wr_en(wr_en),
        .scc_out(scc_out), .illegal(illegal)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [31:0] ins);
        int op;
        op = int'(ins[29:23]);
        if (ins[31:30] != 2'b10) return "R3";
        if (op == 11 || op > 24) return "R4";
        if (op == 0 || op == 4) return "R5";
        if (op == 1 || op == 5) return "R6";
        if (op == 2 || op == 3) return "R7";
        if (op >= 6 && op <= 9) return "R8";
        if (op == 10 || op == 23) return "R9";
        if (op >= 12 && op <= 19) return "R10";
        if (op >= 20 && op <= 22) return "R11";
        return "R12";
    endfunction

    // returns {illegal, wr, flag, result}
    function automatic logic [34:0] model(input logic [31:0] ins, input logic [31:0] a,
                                          input logic [31:0] b, input logic c);
        longint sa, sb, t;
        logic [31:0] r;
        logic f;
        int op;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        op = int'(ins[29:23]);
        r = 0;
        f = c;
        if (ins[31:30] != 2'b10 || op == 11 || op > 24) return {1'b1, 1'b0, c, 32'h0};
        case (op)
            0, 4: begin
                t = longint'(a) + longint'(b) + ((op == 4) ? longint'(c) : 0);
                r = t[31:0]; f = t[32];
            end
            1, 5: begin
                t = longint'(a) - longint'(b) - ((op == 5) ? longint'(c) : 0);
                r = t[31:0]; f = (t < 0);
            end
            2, 3: begin
                t = (op == 2) ? sa + sb : sa - sb;
                r = t[31:0]; f = (t > 64'sd2147483647) || (t < -64'sd2147483648);
            end
            6: begin r = (sa < sb) ? a : b; f = (sa < sb); end
            7: begin r = (a < b) ? a : b; f = (a < b); end
            8: begin r = (sa > sb) ? a : b; f = (sa > sb); end
            9: begin r = (a > b) ? a : b; f = (a > b); end
            10: begin r = c ? a : b; f = c; end
            23: begin t = longint'(a) * longint'(b); r = t[31:0]; f = c; end
            24: begin
                t = sa - sb;
                if (t < 0) t = -t;
                r = t[31:0]; f = (r != 0);
            end
            default: begin
                case (op)
                    12: r = a & b;
                    13: r = a | b;
                    14: r = a ^ b;
                    15: r = a & ~b;
                    16: r = a | ~b;
                    17: r = ~(a & b);
                    18: r = ~(a | b);
                    19: r = ~(a ^ b);
                    20: r = a << (b % 32);
                    21: r = a >> (b % 32);
                    default: r = 32'($signed(a) >>> (b % 32));
                endcase
                f = (r != 0);
            end
        endcase
        return {1'b0, 1'b1, f, r};
    endfunction

    function automatic logic [31:0] mk(input int op, input int dst);
        return {2'b10, 7'(op), 7'(dst), 16'h1234};
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic c);
        logic [34:0] e;
        string tg;
        @(negedge clk);
        in_valid = 1'b1; instr = ins; src0 = a; src1 = b; scc_in = c;
        e  = model(ins, a, b, c);
        tg = tag_of(ins);
        @(negedge clk);
        chk("R2", "out_valid", 32'(out_valid), 32'd1);
        chk("R2", "dst_idx", 32'(dst_idx), 32'(ins[22:16]));
        chk(tg, "illegal", 32'(illegal), 32'(e[34]));
        chk(tg, "wr_en", 32'(wr_en), 32'(e[33]));
        chk(tg, "scc_out", 32'(scc_out), 32'(e[32]));
        chk(tg, "result", result, e[31:0]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        logic        held_f;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "out_valid", 32'(out_valid), 0);
        chk("R1", "wr_en", 32'(wr_en), 0);
        chk("R1", "illegal", 32'(illegal), 0);
        chk("R1", "scc_out", 32'(scc_out), 0);
        chk("R1", "result", result, 0);
        chk("R1", "dst_idx", 32'(dst_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after release", 32'(out_valid), 0);

        issue(mk(0, 5), 32'hFFFF_FFFF, 32'h1, 1'b0);          // R5 carry
        issue(mk(4, 6), 32'hFFFF_FFFE, 32'h1, 1'b1);          // R5 carry-in
        issue(mk(4, 6), 32'h10, 32'h20, 1'b1);                // R5
        issue(mk(1, 7), 32'h0, 32'h1, 1'b0);                  // R6 borrow
        issue(mk(5, 8), 32'h5, 32'h5, 1'b1);                  // R6 borrow-in
        issue(mk(5, 8), 32'h5, 32'h4, 1'b1);                  // R6 no borrow
        issue(mk(2, 9), 32'h7FFF_FFFF, 32'h1, 1'b0);          // R7 overflow
        issue(mk(2, 9), 32'hFFFF_FFFF, 32'h1, 1'b1);          // R7 no overflow
        issue(mk(3, 9), 32'h8000_0000, 32'h1, 1'b0);          // R7 overflow
        issue(mk(6, 1), 32'hFFFF_FFFF, 32'h1, 1'b0);          // R8 signed min
        issue(mk(7, 1), 32'hFFFF_FFFF, 32'h1, 1'b1);          // R8 unsigned min
        issue(mk(8, 2), 32'h42, 32'h42, 1'b1);                // R8 equal max
        issue(mk(9, 2), 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);  // R8
        issue(mk(10, 3), 32'hAAAA_AAAA, 32'h5555_5555, 1'b1); // R9
        issue(mk(10, 3), 32'hAAAA_AAAA, 32'h5555_5555, 1'b0); // R9
        issue(mk(23, 4), 32'hFFFF_FFFF, 32'h3, 1'b1);         // R9 multiply
        issue(mk(12, 10), 32'h0F, 32'hF0, 1'b1);              // R10 zero result
        issue(mk(19, 10), 32'h1234, 32'hFFFF_EDCB, 1'b1);     // R10 xnor zero
        issue(mk(15, 10), 32'hFF, 32'h0F, 1'b0);              // R10 andn
        issue(mk(20, 11), 32'h1, 32'd33, 1'b0);               // R11 mask
        issue(mk(20, 11), 32'h8000_0000, 32'd1, 1'b1);        // R11 shifted out
        issue(mk(22, 11), 32'h8000_0000, 32'd31, 1'b0);       // R11 arithmetic
        issue(mk(21, 11), 32'h8000_0000, 32'd31, 1'b0);       // R11 logical
        issue(mk(24, 12), 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);// R12 wide diff
        issue(mk(24, 12), 32'h3, 32'h3, 1'b1);                // R12 zero
        issue(mk(24, 12), 32'h2, 32'h9, 1'b0);                // R12
        issue({2'b01, 7'd0, 7'd3, 16'h0}, 32'h1, 32'h1, 1'b1); // R3
        issue({2'b11, 7'd12, 7'd3, 16'h0}, 32'h1, 32'h1, 1'b0);// R3
        issue(mk(11, 4), 32'h1, 32'h2, 1'b1);                 // R4
        issue(mk(127, 4), 32'h1, 32'h2, 1'b0);                // R4

        // R2 hold when idle
        issue(mk(13, 9), 32'h00F0, 32'h0F00, 1'b0);
        held = result; held_f = scc_out;
        @(negedge clk);
        in_valid = 1'b0; src0 = 32'h0; instr = mk(0, 0);
        @(negedge clk);
        chk("R2", "idle out_valid", 32'(out_valid), 0);
        chk("R2", "idle wr_en", 32'(wr_en), 0);
        chk("R2", "idle result", result, held);
        chk("R2", "idle scc_out", 32'(scc_out), 32'(held_f));

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ins;
            logic [31:0] a;
            logic [31:0] b;
            int sel;
            sel = int'($urandom_range(0, 15));
            ins = mk(int'($urandom_range(0, 24)), int'($urandom_range(0, 127)));
            if (sel == 0) ins[31:30] = 2'($urandom_range(0, 3));
            if (sel == 1) ins[29:23] = 7'($urandom_range(0, 127));
            a = $urandom();
            b = $urandom();
            if (sel == 2) a = b;
            if (sel == 3) b = 32'($urandom_range(0, 40));
            issue(ins, a, b, 1'($urandom_range(0, 1)));
        end
        @(negedge clk);
        in_valid = 1'b0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule